// File: doc/BRIEF.md
# Staged Infrared Link Mode Configuration

This block holds the configuration of an infrared serial link: the encoding mode (slow, medium or fast rate), the CRC width, the direction enables and the polarity controls, together with a 16-bit physical-layer timing word. The timing word carries a baud divisor, a pulse width and a preamble count. Software programs these through a small register file with one write port and one read port. The encoder and decoder blocks take their settings from the output buses.

The mode selections, the CRC width and the timing word are staged. A write only updates a shadow copy. The shadow is copied into the applied state in the clock edge where the link-enable bit goes from 0 to 1. If more than one encoding mode is selected at that edge, the block raises a configuration-error flag and applies no mode. A read-only status word reports the link enable, the error flag, the applied mode, the applied CRC width and the effective direction enables. The direction, loopback, polarity and filter controls are not staged and act on the next cycle.

Register map (word index on `wrAddr`/`rdAddr`): 0 link configuration, 1 next timing word, 2 applied timing word (read-only), 3 enable/status, 4 maximum receive length. Indices 5 to 7 are unmapped.

Top module: `irmode_stage`

## Requirements
- R1: After reset every register reads 0, the link is disabled and every output is 0.
- R2: The link configuration register keeps only these bits and reads 0 in bits 15, 13 and 8:
  - loopback at 14
  - transmit enable at 12
  - receive enable at 11
  - bus-master enable at 9+1=10
  - accept-any at 9
  - 16-bit CRC at 7
  - fast mode at 6
  - medium mode at 5
  - slow mode at 4
  - receive filter at 3
  - filter test at 2
  - transmit invert at 1
  - receive invert at 0
- R3: The loopback, master, accept-any, filter, test and polarity bits drive their outputs one cycle after the write. The transmit enable drives `txEnable` and status bit 10. The effective receive enable is receive-enable AND (NOT transmit-enable OR loopback). It drives `rxEnable` and status bit 9.
- R4: Writes to the mode bits, the CRC bit or the next timing word do not change the applied mode, the applied CRC, the applied timing register or the timing outputs until the next 0→1 transition of the enable bit.
- R5: A write of 1 to enable bit 15 while the link is disabled applies the staged state in that clock edge:
  - status bits 13, 12 and 11 show the fast, medium and slow modes
  - status bit 8 shows the 16-bit CRC
  - register 2 holds the next timing word
  - `baudDiv`, `pulseWidth` and `preamble` carry bits [15:10], [9:5] and [4:0] of that word
- R6: Writing 1 to the enable bit while the link is already enabled does not re-apply the staged state.
- R7: While the link is disabled, every mode-on bit and the CRC-on bit read 0. Register 2 keeps the last applied timing word.
- R8: If more than one of the three mode bits is set at the apply edge:
  - status bit 14 (configuration error) is set
  - no mode and no CRC setting is applied
  - the timing word is still applied

  The error flag clears when the enable bit is written 0.
- R9: The maximum receive length register stores bits [11:0] only and reads 0 in [15:12]. It drives `maxRxLen`.
- R10: In the enable/status register only bit 15 is writable; writes to bits 14..0 have no effect, and bits 7..0 read 0.
- R11: Writes to register 2 and to indices 5 to 7 have no effect, and indices 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register index for the write |
| wrData | input | 16 | Write data |
| rdAddr | input | ADDR_W | Register index for the read |
| rdData | output | 16 | Read data (combinational from `rdAddr`) |
| phyOn | output | 1 | Link enabled |
| sirOn | output | 1 | Slow mode applied |
| mirOn | output | 1 | Medium mode applied |
| firOn | output | 1 | Fast mode applied |
| crc16On | output | 1 | 16-bit CRC applied |
| cfgError | output | 1 | Illegal mode combination seen at apply |
| txEnable | output | 1 | Transmit enable |
| rxEnable | output | 1 | Effective receive enable |
| loopback | output | 1 | Loopback test mode |
| master | output | 1 | Bus-master enable |
| rxAny | output | 1 | Accept any received packet |
| sirFilter | output | 1 | Slow-mode receive unwrapping filter |
| sirTest | output | 1 | Filter allowed outside slow mode |
| txInvert | output | 1 | Transmit polarity invert |
| rxInvert | output | 1 | Receive polarity invert |
| baudDiv | output | 6 | Applied baud divisor |
| pulseWidth | output | 5 | Applied pulse width |
| preamble | output | 5 | Applied preamble count |
| maxRxLen | output | LEN_W | Maximum receive length |

## Verification
The bench checks that staged writes stay invisible while the link is enabled. A design that applied them at once would change the mode or the timing outputs mid-frame. It repeats the enable write on a running link to catch a design that treated the level as an edge and re-applied the staged state. Conflicting mode selections at the apply edge must raise the error flag and leave every mode-on bit low; a design without this check would drive two encoders at once. Disabling the link must clear the status bits but keep the applied timing word readable. A long run of random writes to every index, unmapped ones included, is compared against a bench model of the staged and applied state.

// File: rtl/irmode_pkg.sv
package irmode_pkg;
  localparam int WORD_W  = 16;
  localparam int BAUD_W  = 6;
  localparam int WIDTH_W = 5;
  localparam int PRE_W   = 5;
  localparam int NMODE   = 3;

  // link configuration bit positions
  localparam int CFG_LOOP  = 14;
  localparam int CFG_TXEN  = 12;
  localparam int CFG_RXEN  = 11;
  localparam int CFG_MSTR  = 10;
  localparam int CFG_RXANY = 9;
  localparam int CFG_CRC16 = 7;
  localparam int CFG_FAST  = 6;
  localparam int CFG_MED   = 5;
  localparam int CFG_SLOW  = 4;
  localparam int CFG_SFILT = 3;
  localparam int CFG_STEST = 2;
  localparam int CFG_TXPOL = 1;
  localparam int CFG_RXPOL = 0;
  localparam logic [WORD_W-1:0] CFG_MASK = 16'h5EFF;

  // enable/status bit positions
  localparam int ST_EN   = 15;
  localparam int ST_ERR  = 14;
  localparam int ST_FAST = 13;
  localparam int ST_MED  = 12;
  localparam int ST_SLOW = 11;
  localparam int ST_TX   = 10;
  localparam int ST_RX   = 9;
  localparam int ST_CRC  = 8;

  typedef enum logic [2:0] {
    REG_LINK    = 3'd0,
    REG_NEXTPHY = 3'd1,
    REG_CURPHY  = 3'd2,
    REG_ENSTAT  = 3'd3,
    REG_RXLEN   = 3'd4
  } regSel_e;

  typedef struct packed {
    logic wrLink;
    logic wrNext;
    logic wrLen;
    logic apply;
    logic drop;
  } stageCtl_t;
endpackage

// File: rtl/irmode_ctrl.sv
module irmode_ctrl
  import irmode_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrEnBit,
  output logic              phyEn,
  output stageCtl_t         ctl
);
  logic hitEnable;

  assign hitEnable  = wrEn && (wrAddr == ADDR_W'(REG_ENSTAT));

  always_comb begin
    ctl        = '0;
    ctl.wrLink = wrEn && (wrAddr == ADDR_W'(REG_LINK));
    ctl.wrNext = wrEn && (wrAddr == ADDR_W'(REG_NEXTPHY));
    ctl.wrLen  = wrEn && (wrAddr == ADDR_W'(REG_RXLEN));
    ctl.apply  = hitEnable && wrEnBit && !phyEn;
    ctl.drop   = hitEnable && !wrEnBit && phyEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) phyEn <= 1'b0;
    else if (hitEnable) phyEn <= wrEnBit;
  end
endmodule

// File: rtl/irmode_dpath.sv
module irmode_dpath
  import irmode_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageCtl_t         ctl,
  input  logic              phyEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic [WORD_W-1:0] linkCfg,
  output logic [WORD_W-1:0] curPhy,
  output logic [NMODE-1:0]  modeOn,
  output logic              crcOn,
  output logic              cfgErr,
  output logic              rxEffective,
  output logic [LEN_W-1:0]  maxLen
);
  logic [WORD_W-1:0] nextPhy;
  logic [NMODE-1:0]  stagedMode;
  logic [NMODE-1:0]  appliedMode;
  logic              appliedCrc;
  logic              multiMode;
  logic [WORD_W-1:0] statusWord;

  // index 0 slow, 1 medium, 2 fast
  assign stagedMode = {linkCfg[CFG_FAST], linkCfg[CFG_MED], linkCfg[CFG_SLOW]};
  assign multiMode  = (stagedMode[0] & stagedMode[1]) |
                      (stagedMode[0] & stagedMode[2]) |
                      (stagedMode[1] & stagedMode[2]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkCfg <= '0;
      nextPhy <= '0;
      maxLen  <= '0;
    end else begin
      if (ctl.wrLink) linkCfg <= wrData & CFG_MASK;
      if (ctl.wrNext) nextPhy <= wrData;
      if (ctl.wrLen)  maxLen  <= wrData[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPhy      <= '0;
      appliedMode <= '0;
      appliedCrc  <= 1'b0;
      cfgErr      <= 1'b0;
    end else if (ctl.apply) begin
      curPhy      <= nextPhy;
      cfgErr      <= multiMode;
      appliedMode <= multiMode ? '0 : stagedMode;
      appliedCrc  <= multiMode ? 1'b0 : linkCfg[CFG_CRC16];
    end else if (ctl.drop) begin
      cfgErr      <= 1'b0;
      appliedMode <= '0;
      appliedCrc  <= 1'b0;
    end
  end

  for (genvar g = 0; g < NMODE; g++) begin : g_modeGate
    assign modeOn[g] = phyEn & appliedMode[g];
  end
  assign crcOn = phyEn & appliedCrc;

  assign rxEffective = linkCfg[CFG_RXEN] &
                       (~linkCfg[CFG_TXEN] | linkCfg[CFG_LOOP]);

  always_comb begin
    statusWord          = '0;
    statusWord[ST_EN]   = phyEn;
    statusWord[ST_ERR]  = cfgErr;
    statusWord[ST_FAST] = modeOn[2];
    statusWord[ST_MED]  = modeOn[1];
    statusWord[ST_SLOW] = modeOn[0];
    statusWord[ST_TX]   = linkCfg[CFG_TXEN];
    statusWord[ST_RX]   = rxEffective;
    statusWord[ST_CRC]  = crcOn;
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_W'(REG_LINK):    rdData = linkCfg;
      ADDR_W'(REG_NEXTPHY): rdData = nextPhy;
      ADDR_W'(REG_CURPHY):  rdData = curPhy;
      ADDR_W'(REG_ENSTAT):  rdData = statusWord;
      ADDR_W'(REG_RXLEN):   rdData = WORD_W'(maxLen);
      default:              rdData = '0;
    endcase
  end
endmodule

// File: rtl/irmode_stage.sv
module irmode_stage
  import irmode_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int LEN_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [15:0]        wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [15:0]        rdData,
  output logic               phyOn,
  output logic               sirOn,
  output logic               mirOn,
  output logic               firOn,
  output logic               crc16On,
  output logic               cfgError,
  output logic               txEnable,
  output logic               rxEnable,
  output logic               loopback,
  output logic               master,
  output logic               rxAny,
  output logic               sirFilter,
  output logic               sirTest,
  output logic               txInvert,
  output logic               rxInvert,
  output logic [5:0]         baudDiv,
  output logic [4:0]         pulseWidth,
  output logic [4:0]         preamble,
  output logic [LEN_W-1:0]   maxRxLen
);
  stageCtl_t         ctl;
  logic              phyEn;
  logic [WORD_W-1:0] linkCfg;
  logic [WORD_W-1:0] curPhy;
  logic [NMODE-1:0]  modeOn;
  logic              crcOn;
  logic              cfgErr;
  logic              rxEff;

  irmode_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrEnBit (wrData[ST_EN]),
    .phyEn   (phyEn),
    .ctl     (ctl)
  );

  irmode_dpath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .phyEn       (phyEn),
    .wrData      (wrData),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .linkCfg     (linkCfg),
    .curPhy      (curPhy),
    .modeOn      (modeOn),
    .crcOn       (crcOn),
    .cfgErr      (cfgErr),
    .rxEffective (rxEff),
    .maxLen      (maxRxLen)
  );

  assign phyOn      = phyEn;
  assign sirOn      = modeOn[0];
  assign mirOn      = modeOn[1];
  assign firOn      = modeOn[2];
  assign crc16On    = crcOn;
  assign cfgError   = cfgErr;
  assign txEnable   = linkCfg[CFG_TXEN];
  assign rxEnable   = rxEff;
  assign loopback   = linkCfg[CFG_LOOP];
  assign master     = linkCfg[CFG_MSTR];
  assign rxAny      = linkCfg[CFG_RXANY];
  assign sirFilter  = linkCfg[CFG_SFILT];
  assign sirTest    = linkCfg[CFG_STEST];
  assign txInvert   = linkCfg[CFG_TXPOL];
  assign rxInvert   = linkCfg[CFG_RXPOL];
  assign baudDiv    = curPhy[WORD_W-1 -: BAUD_W];
  assign pulseWidth = curPhy[PRE_W +: WIDTH_W];
  assign preamble   = curPhy[PRE_W-1:0];
endmodule

// File: rtl/irmode_stage_chk.sv
module irmode_stage_chk #(
  parameter int ADDR_W = 3,
  parameter int LEN_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [15:0]       rdData,
  input logic              phyOn,
  input logic              sirOn,
  input logic              mirOn,
  input logic              firOn,
  input logic              crc16On,
  input logic              cfgError,
  input logic              txEnable,
  input logic              rxEnable,
  input logic              loopback,
  input logic [5:0]        baudDiv,
  input logic [4:0]        pulseWidth,
  input logic [4:0]        preamble
);
  assert_off_no_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    !phyOn |-> !(sirOn || mirOn || firOn || crc16On));

  assert_single_mode_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sirOn, mirOn, firOn}));

  assert_err_blocks_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !(sirOn || mirOn || firOn || crc16On));

  assert_err_needs_phy_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> phyOn);

  assert_held_while_on_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phyOn && $past(phyOn)) |->
      $stable({sirOn, mirOn, firOn, crc16On, cfgError, baudDiv, pulseWidth, preamble}));

  assert_timing_held_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!phyOn && !$past(phyOn)) |-> $stable({baudDiv, pulseWidth, preamble}));

  assert_rx_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable |-> (!txEnable || loopback));

  assert_len_upper_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_W'(4)) |-> (rdData[15:LEN_W] == '0));
endmodule

bind irmode_stage irmode_stage_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .rdAddr     (rdAddr),
  .rdData     (rdData),
  .phyOn      (phyOn),
  .sirOn      (sirOn),
  .mirOn      (mirOn),
  .firOn      (firOn),
  .crc16On    (crc16On),
  .cfgError   (cfgError),
  .txEnable   (txEnable),
  .rxEnable   (rxEnable),
  .loopback   (loopback),
  .baudDiv    (baudDiv),
  .pulseWidth (pulseWidth),
  .preamble   (preamble)
);

// File: tb/irmode_stage_tb_top.sv
module irmode_stage_tb_top;
  localparam int ADDR_W = 3;
  localparam int LEN_W  = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [15:0]       wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [15:0]       rdData;
  logic phyOn, sirOn, mirOn, firOn, crc16On, cfgError, txEnable, rxEnable;
  logic loopback, master, rxAny, sirFilter, sirTest, txInvert, rxInvert;
  logic [5:0] baudDiv;
  logic [4:0] pulseWidth, preamble;
  logic [LEN_W-1:0] maxRxLen;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [15:0] mCfg, mNext, mCur, mLen;
  logic        mEn, mErr, mSlow, mMed, mFast, mCrc;

  always #10 clk = ~clk;

  irmode_stage #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .phyOn(phyOn), .sirOn(sirOn),
    .mirOn(mirOn), .firOn(firOn), .crc16On(crc16On), .cfgError(cfgError),
    .txEnable(txEnable), .rxEnable(rxEnable), .loopback(loopback),
    .master(master), .rxAny(rxAny), .sirFilter(sirFilter), .sirTest(sirTest),
    .txInvert(txInvert), .rxInvert(rxInvert), .baudDiv(baudDiv),
    .pulseWidth(pulseWidth), .preamble(preamble), .maxRxLen(maxRxLen)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] expStatus();
    logic [15:0] s = '0;
    s[15] = mEn;
    s[14] = mErr;
    s[13] = mEn & mFast;
    s[12] = mEn & mMed;
    s[11] = mEn & mSlow;
    s[10] = mCfg[12];
    s[9]  = mCfg[11] & (~mCfg[12] | mCfg[14]);
    s[8]  = mEn & mCrc;
    return s;
  endfunction

  function automatic logic [15:0] expRead(input int a);
    case (a)
      0: return mCfg;
      1: return mNext;
      2: return mCur;
      3: return expStatus();
      4: return mLen;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic modelWrite(input int a, input logic [15:0] d);
    int nm;
    case (a)
      0: mCfg = d & 16'h5EFF;
      1: mNext = d;
      3: begin
        if (d[15] && !mEn) begin
          nm = int'(mCfg[4]) + int'(mCfg[5]) + int'(mCfg[6]);
          mCur = mNext;
          mErr = (nm > 1);
          mSlow = (nm > 1) ? 1'b0 : mCfg[4];
          mMed  = (nm > 1) ? 1'b0 : mCfg[5];
          mFast = (nm > 1) ? 1'b0 : mCfg[6];
          mCrc  = (nm > 1) ? 1'b0 : mCfg[7];
        end else if (!d[15] && mEn) begin
          mErr = 0; mSlow = 0; mMed = 0; mFast = 0; mCrc = 0;
        end
        mEn = d[15];
      end
      4: mLen = {4'h0, d[11:0]};
      default: ;
    endcase
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = ADDR_W'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    rdAddr = ADDR_W'(a);
    #1;
    v = rdData;
  endtask

  task automatic checkAll(input string ctx);
    logic [15:0] v;
    rd(0, v); chk({ctx, " R2 link cfg"}, v, expRead(0));
    rd(1, v); chk({ctx, " R4 next timing"}, v, expRead(1));
    rd(2, v); chk({ctx, " R5 applied timing"}, v, expRead(2));
    rd(3, v); chk({ctx, " R5 R8 status"}, v, expRead(3));
    rd(4, v); chk({ctx, " R9 max len"}, v, expRead(4));
    rd(5 + ($urandom % 3), v); chk({ctx, " R11 unmapped"}, v, 16'h0000);
    chk({ctx, " R3 outputs"},
        {3'b0, loopback, master, rxAny, sirFilter, sirTest, txInvert, rxInvert,
         txEnable, rxEnable, 4'h0},
        {3'b0, mCfg[14], mCfg[10], mCfg[9], mCfg[3], mCfg[2], mCfg[1], mCfg[0],
         mCfg[12], mCfg[11] & (~mCfg[12] | mCfg[14]), 4'h0});
    chk({ctx, " R5 mode outputs"},
        {10'h0, phyOn, cfgError, firOn, mirOn, sirOn, crc16On},
        {10'h0, mEn, mErr, mEn & mFast, mEn & mMed, mEn & mSlow, mEn & mCrc});
    chk({ctx, " R5 timing outputs"}, {baudDiv, pulseWidth, preamble}, mCur);
    chk({ctx, " R9 maxRxLen"}, {4'h0, maxRxLen}, mLen);
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int a;
    logic [15:0] d;
    void'($urandom(32'd1234));
    mCfg = 0; mNext = 0; mCur = 0; mLen = 0;
    mEn = 0; mErr = 0; mSlow = 0; mMed = 0; mFast = 0; mCrc = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");

    // staged slow mode with CRC16, timing word
    wr(0, 16'h1890 | 16'h0080);
    wr(1, 16'h2D8B);
    rd(3, v); chk("R4 status before enable", v, 16'h0400);
    rd(2, v); chk("R4 timing not yet applied", v, 16'h0000);
    wr(3, 16'h8000);
    rd(3, v); chk("R5 slow mode applied", v, 16'h8D00);
    chk("R5 baud field", {10'h0, baudDiv}, 16'h000B);
    chk("R5 width field", {11'h0, pulseWidth}, 16'h000C);
    chk("R5 preamble field", {11'h0, preamble}, 16'h000B);
    checkAll("R5 apply");

    // staged change while enabled
    wr(0, 16'h0020);
    wr(1, 16'h0021);
    rd(3, v); chk("R4 shadow hidden while on", v, 16'h8900 & 16'hF9FF);
    wr(3, 16'h8000);
    rd(3, v); chk("R6 no re-apply", v, 16'h8900 & 16'hF9FF);
    chk("R6 timing held", {baudDiv, pulseWidth, preamble}, 16'h2D8B);
    checkAll("R6 repeat enable");

    // disable
    wr(3, 16'h0000);
    rd(3, v); chk("R7 status off", v, 16'h0000);
    rd(2, v); chk("R7 applied timing kept", v, 16'h2D8B);
    wr(3, 16'h8000);
    chk("R5 medium mode", {15'h0, mirOn}, 16'h0001);
    checkAll("R7 reapply");

    // conflict
    wr(3, 16'h0000);
    wr(0, 16'h0050);
    wr(1, 16'h01E0);
    wr(3, 16'h8000);
    rd(3, v); chk("R8 error flagged", v, 16'hC000);
    rd(2, v); chk("R8 timing applied", v, 16'h01E0);
    wr(3, 16'h0000);
    rd(3, v); chk("R8 error cleared", v, 16'h0000);

    // enable register low bits, max length, read-only writes
    wr(3, 16'h7FFF);
    rd(3, v); chk("R10 low bits ignored", v, 16'h0000);
    wr(4, 16'hFFFF);
    rd(4, v); chk("R9 len masked", v, 16'h0FFF);
    wr(2, 16'hAAAA);
    rd(2, v); chk("R11 applied timing read-only", v, 16'h01E0);
    wr(6, 16'h5555);
    checkAll("R11 unmapped write");
    wr(0, 16'hFFFF);
    rd(0, v); chk("R2 cfg mask", v, 16'h5EFF);
    chk("R3 rx gated by loopback", {15'h0, rxEnable}, 16'h0001);
    wr(0, 16'h1800);
    chk("R3 rx blocked by tx", {15'h0, rxEnable}, 16'h0000);

    // random mix
    for (int i = 0; i < 400; i++) begin
      a = $urandom % 8;
      d = 16'($urandom);
      if (a == 3 && ($urandom % 2) == 0) d[15] = mEn;
      if (a == 0 && ($urandom % 2) == 0) d[6:4] = 3'b001 << ($urandom % 3);
      wr(a, d);
      checkAll("random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule